// File: doc/BRIEF.md
# Programmable Address Window Decoder

This block steers CPU physical addresses to downstream targets through eight register-programmed windows. Each window has a control word, a base address and, on the lower-numbered windows, a remap base. The control word holds the enable, a target ID, an attribute byte and the window's size minus one. Software writes these through a simple synchronous configuration port and can read every register back.

The lookup side is purely combinational. It takes a 32-bit address and reports whether any window claims it. On a hit it also gives the index of the winning window, that window's target ID and attribute, and the outgoing address. On a remap-capable window the outgoing address is translated at 64 KB granularity. On every other window it equals the incoming address.

Top module: `addr_win_decoder`

## Requirements
- R1: After reset every register reads zero, every window is disabled, and every lookup misses.
- R2: Window w's registers start at byte offset 16*w, with cfg_addr[6:4] selecting the window. Within a window, cfg_addr[3:2] selects the register: 0 is control, 1 is base, 2 is remap-low and 3 is remap-high. Control reads back bits 31:16 (size minus one), 15:8 (attribute), 7:4 (target) and 0 (enable), with bits 3:1 reading zero. Base and remap-low keep bits 31:16 only, with bits 15:0 reading zero. Remap-high keeps all 32 bits. A write takes effect at the clock edge on which cfg_wr_en is high, and read data is combinational from cfg_addr.
- R3: Writes to the remap-low or remap-high offsets of windows 4 to 7 are ignored, and those offsets always read zero.
- R4: A window hits when its enable bit is set and (addr[31:16] & ~S) equals (base[31:16] & ~S), where S is control bits 31:16.
- R5: When several windows hit, the window with the lowest index is reported.
- R6: On a hit in windows 0 to 3, lk_xaddr is {(remap[31:16] & ~S) | (addr[31:16] & S), addr[15:0]}. If remap-low equals the base, the address therefore passes through unchanged. Remap-high has no effect on translation.
- R7: On a hit in windows 4 to 7, lk_xaddr equals lk_addr.
- R8: On a miss, lk_hit is 0 and lk_win, lk_target and lk_attr are 0, and lk_xaddr equals lk_addr.
- R9: On a hit, lk_win is the winning index, lk_target is its control bits 7:4 and lk_attr is its control bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register byte offset for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| lk_addr | input | 32 | Address to look up |
| lk_hit | output | 1 | Some enabled window claims lk_addr |
| lk_win | output | 3 | Index of the winning window |
| lk_target | output | 4 | Target ID of the winning window |
| lk_attr | output | 8 | Attribute of the winning window |
| lk_xaddr | output | 32 | Outgoing (translated) address |

## Verification
The assertions check on every cycle the properties that need no knowledge of the stored configuration:
- quiet miss outputs;
- the low 16 address bits passing straight through;
- the pass-through on windows 4 to 7;
- lowest-index selection among the per-window match lines;
- reads of absent remap registers being zero;
- base readback after a write.

Only the bench's scenarios can show the rest, because these depend on a reference model of the programmed windows:
- the base/size match rule, including the exact window edges;
- the translated upper bits;
- remap-high having no effect;
- priority among overlapping windows that are programmed on purpose.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  localparam int AW     = 32;
  localparam int GRAN   = 16;
  localparam int HI_W   = AW - GRAN;
  localparam int TGT_W  = 4;
  localparam int ATTR_W = 8;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_BASE = 2'd1;
  localparam logic [1:0] OFS_RLO  = 2'd2;
  localparam logic [1:0] OFS_RHI  = 2'd3;

  typedef struct packed {
    logic [HI_W-1:0]   size_m1;
    logic [ATTR_W-1:0] attr;
    logic [TGT_W-1:0]  target;
    logic              en;
  } win_ctrl_t;

  typedef struct packed {
    win_ctrl_t       ctrl;
    logic [HI_W-1:0] base;
    logic [HI_W-1:0] remap;
  } win_cfg_t;

  function automatic logic [AW-1:0] pack_ctrl(win_ctrl_t c);
    return {c.size_m1, c.attr, c.target, 3'b000, c.en};
  endfunction
endpackage

// File: rtl/win_regfile.sv
module win_regfile
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CFG_AW   = WIN_W + 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CFG_AW-1:0]        addr,
  input  logic [AW-1:0]            wdata,
  output logic [AW-1:0]            rdata,
  output win_cfg_t [NUM_WIN-1:0]   cfg_o
);
  logic [WIN_W-1:0] sel_win;
  logic [1:0]       sel_reg;
  logic [AW-1:0]    rd_word [NUM_WIN];
  logic             unused_bits;

  assign sel_win     = addr[CFG_AW-1:4];
  assign sel_reg     = addr[3:2];
  assign unused_bits = ^{addr[1:0], wdata[3:1]};

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic            wr_sel;
    logic            ctrl_we, base_we;
    win_ctrl_t       ctrl_q, ctrl_d;
    logic [HI_W-1:0] base_q, base_d;
    logic [HI_W-1:0] rlo_val;
    logic [AW-1:0]   rhi_val;

    assign wr_sel  = wr_en && (sel_win == WIN_W'(w));
    assign ctrl_we = wr_sel && (sel_reg == OFS_CTRL);
    assign base_we = wr_sel && (sel_reg == OFS_BASE);

    always_comb begin
      ctrl_d.size_m1 = wdata[31:16];
      ctrl_d.attr    = wdata[15:8];
      ctrl_d.target  = wdata[7:4];
      ctrl_d.en      = wdata[0];
      base_d         = wdata[AW-1:GRAN];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ctrl_q <= '0;
        base_q <= '0;
      end else begin
        if (ctrl_we) ctrl_q <= ctrl_d;
        if (base_we) base_q <= base_d;
      end
    end

    if (w < NUM_REMAP) begin : g_remap
      logic            rlo_we, rhi_we;
      logic [HI_W-1:0] rlo_q, rlo_d;
      logic [AW-1:0]   rhi_q, rhi_d;

      assign rlo_we = wr_sel && (sel_reg == OFS_RLO);
      assign rhi_we = wr_sel && (sel_reg == OFS_RHI);

      always_comb begin
        rlo_d = wdata[AW-1:GRAN];
        rhi_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rlo_q <= '0;
          rhi_q <= '0;
        end else begin
          if (rlo_we) rlo_q <= rlo_d;
          if (rhi_we) rhi_q <= rhi_d;
        end
      end

      assign rlo_val = rlo_q;
      assign rhi_val = rhi_q;
    end else begin : g_fixed
      assign rlo_val = '0;
      assign rhi_val = '0;
    end

    assign rd_word[w] = (sel_reg == OFS_CTRL) ? pack_ctrl(ctrl_q)        :
                        (sel_reg == OFS_BASE) ? {base_q, {GRAN{1'b0}}}   :
                        (sel_reg == OFS_RLO)  ? {rlo_val, {GRAN{1'b0}}}  :
                                                rhi_val;

    assign cfg_o[w] = '{ctrl: ctrl_q, base: base_q, remap: rlo_val};
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (sel_win == WIN_W'(w)) rdata = rd_word[w];
    end
  end
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4
) (
  input  win_cfg_t [NUM_WIN-1:0]        cfg_i,
  input  logic [AW-1:0]                 addr,
  output logic [NUM_WIN-1:0]            hit_vec,
  output logic [NUM_WIN-1:0][AW-1:0]    xaddr_vec
);
  logic [HI_W-1:0] addr_hi;
  assign addr_hi = addr[AW-1:GRAN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [HI_W-1:0] keep;
    logic [HI_W-1:0] out_hi;

    assign keep       = ~cfg_i[w].ctrl.size_m1;
    assign hit_vec[w] = cfg_i[w].ctrl.en &&
                        ((addr_hi & keep) == (cfg_i[w].base & keep));

    if (w < NUM_REMAP) begin : g_xlate
      assign out_hi = (cfg_i[w].remap & keep) | (addr_hi & cfg_i[w].ctrl.size_m1);
    end else begin : g_pass
      logic unused_remap;
      assign unused_remap = ^cfg_i[w].remap;
      assign out_hi       = addr_hi;
    end

    assign xaddr_vec[w] = {out_hi, addr[GRAN-1:0]};
  end
endmodule

// File: rtl/win_select.sv
module win_select
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  localparam int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
  input  win_cfg_t [NUM_WIN-1:0]        cfg_i,
  input  logic [AW-1:0]                 addr,
  input  logic [NUM_WIN-1:0]            hit_vec,
  input  logic [NUM_WIN-1:0][AW-1:0]    xaddr_vec,
  output logic                          hit,
  output logic [WIN_W-1:0]              win,
  output logic [TGT_W-1:0]              target,
  output logic [ATTR_W-1:0]             attr,
  output logic [AW-1:0]                 xaddr
);
  always_comb begin
    hit    = 1'b0;
    win    = '0;
    target = '0;
    attr   = '0;
    xaddr  = addr;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit    = 1'b1;
        win    = WIN_W'(w);
        target = cfg_i[w].ctrl.target;
        attr   = cfg_i[w].ctrl.attr;
        xaddr  = xaddr_vec[w];
      end
    end
  end
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CFG_AW   = WIN_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]     cfg_wdata,
  output logic [AW-1:0]     cfg_rdata,
  input  logic [AW-1:0]     lk_addr,
  output logic              lk_hit,
  output logic [WIN_W-1:0]  lk_win,
  output logic [TGT_W-1:0]  lk_target,
  output logic [ATTR_W-1:0] lk_attr,
  output logic [AW-1:0]     lk_xaddr
);
  win_cfg_t [NUM_WIN-1:0]     cfg;
  logic [NUM_WIN-1:0]         hit_vec;
  logic [NUM_WIN-1:0][AW-1:0] xaddr_vec;

  win_regfile #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg_o (cfg)
  );

  win_match #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_match (
    .cfg_i     (cfg),
    .addr      (lk_addr),
    .hit_vec   (hit_vec),
    .xaddr_vec (xaddr_vec)
  );

  win_select #(.NUM_WIN(NUM_WIN)) u_sel (
    .cfg_i     (cfg),
    .addr      (lk_addr),
    .hit_vec   (hit_vec),
    .xaddr_vec (xaddr_vec),
    .hit       (lk_hit),
    .win       (lk_win),
    .target    (lk_target),
    .attr      (lk_attr),
    .xaddr     (lk_xaddr)
  );
endmodule

// File: rtl/addr_win_checker.sv
module addr_win_checker
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN   = 8,
  parameter int NUM_REMAP = 4,
  localparam int WIN_W    = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
  localparam int CFG_AW   = WIN_W + 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [CFG_AW-1:0] cfg_addr,
  input logic [AW-1:0]     cfg_wdata,
  input logic [AW-1:0]     cfg_rdata,
  input logic [AW-1:0]     lk_addr,
  input logic              lk_hit,
  input logic [WIN_W-1:0]  lk_win,
  input logic [TGT_W-1:0]  lk_target,
  input logic [ATTR_W-1:0] lk_attr,
  input logic [AW-1:0]     lk_xaddr,
  input logic [NUM_WIN-1:0] hit_vec
);
  logic [WIN_W-1:0] cw;
  logic [NUM_WIN-1:0] below;
  assign cw    = cfg_addr[CFG_AW-1:4];
  assign below = ~({NUM_WIN{1'b1}} << lk_win);

  p_miss_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_target == '0 && lk_attr == '0 && lk_win == '0 && lk_xaddr == lk_addr));

  p_low_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lk_xaddr[GRAN-1:0] == lk_addr[GRAN-1:0]);

  p_fixed_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && int'(lk_win) >= NUM_REMAP) |-> lk_xaddr == lk_addr);

  p_lowest_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (hit_vec[lk_win] && ((hit_vec & below) == '0)));

  p_no_remap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cw) >= NUM_REMAP && cfg_addr[3]) |-> cfg_rdata == '0);

  p_base_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_wr_en) && $past(cfg_addr) == cfg_addr && cfg_addr[3:2] == OFS_BASE &&
     int'(cw) < NUM_WIN)
    |-> cfg_rdata == {$past(cfg_wdata[AW-1:GRAN]), {GRAN{1'b0}}});
endmodule

bind addr_win_decoder addr_win_checker #(.NUM_WIN(NUM_WIN), .NUM_REMAP(NUM_REMAP)) u_chk (.*);

// File: tb/sim_addr_win_decoder.sv
module sim_addr_win_decoder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr;
  logic        lk_hit;
  logic [2:0]  lk_win;
  logic [3:0]  lk_target;
  logic [7:0]  lk_attr;
  logic [31:0] lk_xaddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [31:0] m_ctrl [8];
  logic [31:0] m_base [8];
  logic [31:0] m_rlo  [8];
  logic [31:0] m_rhi  [8];

  always #4 clk = ~clk;

  addr_win_decoder u0 (.*);

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(logic [6:0] a);
    logic [2:0] w = a[6:4];
    case (a[3:2])
      2'd0:    return m_ctrl[w];
      2'd1:    return m_base[w];
      2'd2:    return m_rlo[w];
      default: return m_rhi[w];
    endcase
  endfunction

  function automatic logic [47:0] m_look(logic [31:0] a);
    logic [47:0] r = {1'b0, 3'd0, 4'd0, 8'd0, a};
    for (int w = 7; w >= 0; w--) begin
      logic [15:0] s = m_ctrl[w][31:16];
      if (m_ctrl[w][0] && ((a[31:16] & ~s) == (m_base[w][31:16] & ~s))) begin
        logic [15:0] hi = (w < 4) ? ((m_rlo[w][31:16] & ~s) | (a[31:16] & s)) : a[31:16];
        r = {1'b1, 3'(w), m_ctrl[w][7:4], m_ctrl[w][15:8], hi, a[15:0]};
      end
    end
    return r;
  endfunction

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    case (a[3:2])
      2'd0: m_ctrl[a[6:4]] = d & 32'hFFFF_FFF1;
      2'd1: m_base[a[6:4]] = d & 32'hFFFF_0000;
      2'd2: if (a[6:4] < 4) m_rlo[a[6:4]] = d & 32'hFFFF_0000;
      default: if (a[6:4] < 4) m_rhi[a[6:4]] = d;
    endcase
  endtask

  task automatic rd_chk(string req, logic [6:0] a);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, 64'(cfg_rdata), 64'(m_read(a)));
  endtask

  task automatic lk_chk(string req, logic [31:0] a);
    @(negedge clk);
    lk_addr = a;
    #1;
    chk(req, 64'({lk_hit, lk_win, lk_target, lk_attr, lk_xaddr}), 64'(m_look(a)));
  endtask

  task automatic set_win(int w, logic [15:0] sz, logic [7:0] at, logic [3:0] tg,
                         logic en, logic [15:0] base, logic [15:0] rmp);
    wr(7'(w * 16 + 4), {base, 16'h0});
    wr(7'(w * 16 + 8), {rmp, 16'h0});
    wr(7'(w * 16), {sz, at, tg, 3'b000, en});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) begin
      m_ctrl[i] = 0; m_base[i] = 0; m_rlo[i] = 0; m_rhi[i] = 0;
    end
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0; lk_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 128; a += 4) rd_chk("R1 reset readback", 7'(a));
    for (int i = 0; i < 8; i++) lk_chk("R1 reset miss", $urandom());
    lk_chk("R1 reset miss zero", 32'h0);

    // R2: field masking on control and base
    wr(7'h30, 32'hFFFF_FFFF);
    rd_chk("R2 ctrl bits 3:1 zero", 7'h30);
    wr(7'h34, 32'h1234_ABCD);
    rd_chk("R2 base low bits zero", 7'h34);
    wr(7'h30, 32'h0);

    // R3: remap registers absent on windows 4..7
    wr(7'h58, 32'hDEAD_BEEF);
    wr(7'h5C, 32'hCAFE_F00D);
    rd_chk("R3 remap-low ignored", 7'h58);
    rd_chk("R3 remap-high ignored", 7'h5C);
    wr(7'h7C, 32'hFFFF_FFFF);
    rd_chk("R3 remap-high w7 ignored", 7'h7C);

    // R7, R9: window 5, 64 KB, no translation even with remap attempted
    set_win(5, 16'h0000, 8'hFD, 4'h1, 1'b1, 16'hF800, 16'h1111);
    lk_chk("R7 fixed window pass", 32'hF800_1234);
    lk_chk("R9 target attr", 32'hF800_FFFF);
    lk_chk("R4 just above window", 32'hF801_0000);
    lk_chk("R4 just below window", 32'hF7FF_FFFF);

    // R6: window 0 translated, 1 MB
    set_win(0, 16'h000F, 8'hE0, 4'h4, 1'b1, 16'hF200, 16'h00C0);
    lk_chk("R6 translate start", 32'hF200_0000);
    lk_chk("R6 translate end", 32'hF20F_FFFF);
    lk_chk("R6 translate mid", 32'hF205_4321);
    wr(7'h0C, 32'hFFFF_FFFF);
    rd_chk("R2 remap-high stored", 7'h0C);
    lk_chk("R6 remap-high no effect", 32'hF207_0001);

    // R6: remap equal to base passes through
    set_win(1, 16'h00FF, 8'hE8, 4'h8, 1'b1, 16'hE000, 16'hE000);
    lk_chk("R6 remap equals base", 32'hE0AB_CDEF);

    // R5: overlapping windows 2 and 6
    set_win(6, 16'h0FFF, 8'h00, 4'hD, 1'b1, 16'h8000, 16'h0000);
    set_win(2, 16'h00FF, 8'h01, 4'h3, 1'b1, 16'h8100, 16'h4100);
    lk_chk("R5 lower index wins", 32'h8150_0000);
    lk_chk("R5 only upper window", 32'h8050_0000);
    wr(7'h20, 32'h00FF_0130);
    lk_chk("R4 disabled window skipped", 32'h8150_0000);
    lk_chk("R8 miss outside all", 32'h1000_0000);

    // Random rounds
    for (int rnd = 0; rnd < 30; rnd++) begin
      for (int w = 0; w < 8; w++) begin
        int k = $urandom_range(0, 16);
        logic [15:0] sz = 16'((17'd1 << k) - 17'd1);
        set_win(w, sz, 8'($urandom()), 4'($urandom()), 1'($urandom_range(0, 3) != 0),
                16'($urandom()), 16'($urandom()));
        if ($urandom_range(0, 1) == 1) wr(7'(w * 16 + 12), $urandom());
      end
      for (int a = 0; a < 128; a += 4) rd_chk("R2 random readback", 7'(a));
      for (int j = 0; j < 24; j++) begin
        logic [31:0] a;
        if (j % 2 == 0) begin
          int w = $urandom_range(0, 7);
          logic [15:0] s = m_ctrl[w][31:16];
          a = {(m_base[w][31:16] & ~s) | (16'($urandom()) & s), 16'($urandom())};
          lk_chk("R4 R5 R6 R7 R9 random in-window", a);
        end else begin
          a = $urandom();
          lk_chk("R8 R4 random address", a);
        end
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule